// File: doc/BRIEF.md
# Interrupt Controller Register Bank

This block is the bus-facing register file of a vectored interrupt controller. A processor reaches it through a simple 32-bit port with byte strobes and single-cycle-latency reads. The block holds little state itself. Enable, pending, active and priority state belong to a separate per-vector store. This block decodes writes into one-cycle set, clear and priority-update strobes toward that store, and it formats the store's status back onto the read bus. Priority arbitration and the exception lifecycle are handled elsewhere. This block only reports the results of those functions through status inputs.

Several registers do live here. The block keeps the priority-grouping field, which is guarded by a write key. It keeps the vector table base, which is stored with its low seven bits forced to zero. It keeps three fault status words, which are set by fault sources and cleared by writing ones. Set and clear bitmaps come in pairs of aliases that read back the same status. A single control/state word carries separate set and clear bit pairs for the software-service and timer exceptions. A software trigger register pends an external vector, but only for privileged accesses or when a user-pend permission input is high.

Top module: `irq_regbank`

## Requirements
- R1: A write to the enable-set word at 0x100+4w (or enable-clear at 0x180+4w) gives a one-cycle `ena_set` (or `ena_clr`) strobe on line 32w+j in the cycle after the write, for every written data bit j that is 1. Zero bits have no effect, and words past the last line are ignored. Reads of either alias return `ena_stat` for that word, and return zero past the last line.
- R2: The pending words behave the same way: set at 0x200+4w, clear at 0x280+4w, strobes `pend_set`/`pend_clr`, and both aliases read `pend_stat`.
- R3: The active words at 0x300+4w read `act_stat`. A write there produces no strobe on any output.
- R4: On bitmap and priority writes, only the byte lanes whose `bus_be` bit is high take effect. Lane k covers data bits 8k+7..8k.
- R5: A priority write to 0x400+4k raises `prio_we` for the enabled lanes that map to existing lines, with `prio_exc` = 16+4k (the exception number of lane 0) and `prio_wdata` = written data, one cycle after the write. A read returns byte i = `prio_stat` byte 4k+i, or zero past the last line.
- R6: System priority words 0xD18, 0xD1C and 0xD20 write with `prio_exc` = address−0xD14. They read `sys_prio_stat`, whose byte b belongs to exception 4+b.
- R7: A read of 0xD04 returns `cur_exc` in bits 8:0, `ret_to_base` in bit 11, `pend_vec` in bits 20:12, `ext_pend` in bit 22, `tick_pend` in bit 26, `soft_pend` in bit 28 and `nmi_pend` in bit 31. All other bits are 0.
- R8: A write to 0xD04 has these effects. Bit 31 pulses `nmi_set`. Bit 28 pulses `soft_set`; otherwise bit 27 pulses `soft_clr`. Bit 26 pulses `tick_set`; otherwise bit 25 pulses `tick_clr`.
- R9: A write to 0xD0C has effect only when data bits 31:16 equal 0x05FA. It then loads `prio_group` from bits 10:8, and if bit 2 is set it pulses `sys_rst_req` for one cycle. A read returns 0xFA05 in bits 31:16 and `prio_group` in bits 10:8.
- R10: A write to 0xF00 pulses `pend_set` for line data[8:0], but only when that line exists and `bus_priv` or `usr_pend_en` is high.
- R11: Fault words at 0xD28, 0xD2C and 0xD30 are `flt_stat` words 0, 1 and 2. Each bit is set by the matching `flt_set` bit and cleared by writing a 1. A set in the same cycle as a clear wins.
- R12: A write to 0xD08 stores the data ANDed with 0xFFFFFF80 into `vtab_base`, which reads back at 0xD08. The word at 0x004 reads (NUM_EXT/32)−1.
- R13: `bus_rdata` and `bus_rvalid` are updated one cycle after a read. Unmapped offsets read zero and ignore writes. Writes to the control, key, trigger, fault and vector-base words need all four byte strobes, and are ignored otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane strobes |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| ena_stat | input | NUM_EXT | Enable bits per external line |
| pend_stat | input | NUM_EXT | Pending bits per external line |
| act_stat | input | NUM_EXT | Active bits per external line |
| prio_stat | input | 8*NUM_EXT | Priority byte per external line |
| sys_prio_stat | input | 96 | Priority bytes of exceptions 4..15 |
| cur_exc | input | 9 | Number of the running exception |
| pend_vec | input | 9 | Highest pending exception number |
| ret_to_base | input | 1 | At most one exception active |
| ext_pend | input | 1 | Any external line pending |
| tick_pend | input | 1 | Timer exception pending |
| soft_pend | input | 1 | Software-service exception pending |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| usr_pend_en | input | 1 | Unprivileged software trigger allowed |
| flt_set | input | 96 | Fault set bits, three 32-bit words |
| ena_set | output | NUM_EXT | Enable set strobes |
| ena_clr | output | NUM_EXT | Enable clear strobes |
| pend_set | output | NUM_EXT | Pending set strobes |
| pend_clr | output | NUM_EXT | Pending clear strobes |
| prio_we | output | 4 | Priority byte-lane write strobes |
| prio_exc | output | 9 | Exception number of lane 0 |
| prio_wdata | output | 32 | Priority write data |
| nmi_set | output | 1 | Pend the non-maskable interrupt |
| soft_set | output | 1 | Pend the software-service exception |
| soft_clr | output | 1 | Unpend the software-service exception |
| tick_set | output | 1 | Pend the timer exception |
| tick_clr | output | 1 | Unpend the timer exception |
| sys_rst_req | output | 1 | System reset request pulse |
| prio_group | output | 3 | Priority grouping field |
| vtab_base | output | 32 | Vector table base |
| flt_stat | output | 96 | Fault status words |

## Verification
Most of this block is decode, so a fault in it shows up as a strobe on the wrong line, on the wrong lane or on the wrong exception number. Such a fault is visible at the ports exactly one cycle after the write. Faults in the few state registers show up differently. A wrong grouping field, vector base or fault word appears on its output at once, and a read of that register shows it one cycle later. A key check that accepts a bad key changes `prio_group` in the cycle after the write. A wrong privilege gate or range gate on the trigger shows as a spurious or missing `pend_set` pulse.

// File: rtl/irq_regbank_pkg.sv
package irq_regbank_pkg;
   localparam logic [11:0] OFS_TYPE   = 12'h004;
   localparam logic [11:0] OFS_CTRL   = 12'hD04;
   localparam logic [11:0] OFS_VTAB   = 12'hD08;
   localparam logic [11:0] OFS_APP    = 12'hD0C;
   localparam logic [11:0] OFS_FLT0   = 12'hD28;
   localparam logic [11:0] OFS_TRIG   = 12'hF00;
   localparam logic [15:0] APP_KEY_WR = 16'h05FA;
   localparam logic [15:0] APP_KEY_RD = 16'hFA05;
   localparam int          EXT_BASE   = 16;
   localparam int          NUM_FLT    = 3;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction
endpackage

// File: rtl/irq_rb_bitmap.sv
module irq_rb_bitmap #(
   parameter int          NUM_EXT  = 64,
   parameter logic [11:0] SET_OFS  = 12'h100,
   parameter logic [11:0] CLR_OFS  = 12'h180,
   parameter bit          WRITABLE = 1'b1
) (
   input  logic               wr,
   input  logic [11:0]        addr,
   input  logic [31:0]        wdata,
   input  logic [3:0]         be,
   input  logic [NUM_EXT-1:0] stat,
   output logic [NUM_EXT-1:0] set_o,
   output logic [NUM_EXT-1:0] clr_o,
   output logic [31:0]        rd_word
);
   import irq_regbank_pkg::*;
   localparam int NW = NUM_EXT / 32;

   logic [3:0]  widx;
   logic        set_hit, clr_hit;
   logic [31:0] eff;

   assign widx    = addr[5:2];
   assign set_hit = (addr[11:6] == SET_OFS[11:6]);
   assign clr_hit = (addr[11:6] == CLR_OFS[11:6]);
   assign eff     = wdata & lane_mask(be);

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NW; w++)
         if ((set_hit || clr_hit) && widx == 4'(w)) rd_word = stat[w*32 +: 32];
   end

   generate
      if (WRITABLE) begin : g_rw
         for (genvar g = 0; g < NW; g++) begin : g_word
            assign set_o[g*32 +: 32] = (wr && set_hit && widx == 4'(g)) ? eff : 32'h0;
            assign clr_o[g*32 +: 32] = (wr && clr_hit && widx == 4'(g)) ? eff : 32'h0;
         end
      end else begin : g_ro
         assign set_o = '0;
         assign clr_o = '0;
      end
   endgenerate
endmodule

// File: rtl/irq_rb_prio.sv
module irq_rb_prio #(
   parameter int NUM_EXT = 64
) (
   input  logic                 wr,
   input  logic [11:0]          addr,
   input  logic [3:0]           be,
   input  logic [8*NUM_EXT-1:0] prio_stat,
   input  logic [95:0]          sys_prio_stat,
   output logic [3:0]           we_o,
   output logic [8:0]           exc_o,
   output logic [31:0]          rd_word
);
   import irq_regbank_pkg::*;

   logic ext_hit, sys_hit;
   int   ext_first, sys_first;

   assign ext_hit   = (addr >= 12'h400) && (addr < 12'h5F0);
   assign sys_hit   = (addr >= 12'hD18) && (addr < 12'hD24);
   assign ext_first = int'(addr[8:2]) * 4;
   assign sys_first = int'({addr[11:2], 2'b00}) - 'hD18;

   always_comb begin
      we_o    = '0;
      exc_o   = '0;
      rd_word = '0;
      if (ext_hit) begin
         exc_o = 9'(EXT_BASE + ext_first);
         for (int i = 0; i < 4; i++)
            if (ext_first + i < NUM_EXT) begin
               we_o[i] = wr && be[i];
               rd_word[i*8 +: 8] = prio_stat[(ext_first + i)*8 +: 8];
            end
      end else if (sys_hit) begin
         exc_o = 9'(sys_first + 4);
         for (int i = 0; i < 4; i++) begin
            we_o[i] = wr && be[i];
            rd_word[i*8 +: 8] = sys_prio_stat[(sys_first + i)*8 +: 8];
         end
      end
   end
endmodule

// File: rtl/irq_rb_sysctl.sv
module irq_rb_sysctl #(
   parameter int NUM_EXT = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [11:0]        addr,
   input  logic [31:0]        wdata,
   input  logic [3:0]         be,
   input  logic               priv,
   input  logic               usr_pend_en,
   input  logic [8:0]         cur_exc,
   input  logic [8:0]         pend_vec,
   input  logic               ret_to_base,
   input  logic               ext_pend,
   input  logic               tick_pend,
   input  logic               soft_pend,
   input  logic               nmi_pend,
   input  logic [95:0]        flt_set,
   output logic               nmi_set_d,
   output logic               soft_set_d,
   output logic               soft_clr_d,
   output logic               tick_set_d,
   output logic               tick_clr_d,
   output logic               rst_req_d,
   output logic [NUM_EXT-1:0] trig_vec,
   output logic [2:0]         prio_group,
   output logic [31:0]        vtab_base,
   output logic [95:0]        flt_stat,
   output logic [31:0]        rd_word
);
   import irq_regbank_pkg::*;

   logic       wok, ctrl_wr, app_wr, trig_ok;
   logic [8:0] trig_idx;

   assign wok      = wr && (be == 4'hF);
   assign ctrl_wr  = wok && addr == OFS_CTRL;
   assign app_wr   = wok && addr == OFS_APP && wdata[31:16] == APP_KEY_WR;
   assign trig_idx = wdata[8:0];
   assign trig_ok  = wok && addr == OFS_TRIG && (int'(trig_idx) < NUM_EXT)
                     && (priv || usr_pend_en);

   assign nmi_set_d  = ctrl_wr && wdata[31];
   assign soft_set_d = ctrl_wr && wdata[28];
   assign soft_clr_d = ctrl_wr && !wdata[28] && wdata[27];
   assign tick_set_d = ctrl_wr && wdata[26];
   assign tick_clr_d = ctrl_wr && !wdata[26] && wdata[25];
   assign rst_req_d  = app_wr && wdata[2];

   generate
      for (genvar g = 0; g < NUM_EXT; g++) begin : g_trig
         assign trig_vec[g] = trig_ok && (trig_idx == 9'(g));
      end
      for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
         localparam logic [11:0] FOFS = OFS_FLT0 + 12'(4 * f);
         logic [31:0] clr_bits;
         assign clr_bits = (wok && addr == FOFS) ? wdata : 32'h0;
         always_ff @(posedge clk) begin
            if (!rst_n) flt_stat[f*32 +: 32] <= '0;
            else        flt_stat[f*32 +: 32] <= (flt_stat[f*32 +: 32] & ~clr_bits)
                                                | flt_set[f*32 +: 32];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio_group <= '0;
         vtab_base  <= '0;
      end else begin
         if (app_wr) prio_group <= wdata[10:8];
         if (wok && addr == OFS_VTAB) vtab_base <= wdata & 32'hFFFF_FF80;
      end
   end

   always_comb begin
      rd_word = '0;
      case (addr)
         OFS_TYPE: rd_word = 32'(NUM_EXT / 32 - 1);
         OFS_CTRL: rd_word = {nmi_pend, 2'b00, soft_pend, 1'b0, tick_pend, 3'b000,
                              ext_pend, 1'b0, pend_vec, ret_to_base, 2'b00, cur_exc};
         OFS_VTAB: rd_word = vtab_base;
         OFS_APP:  rd_word = {APP_KEY_RD, 5'b0, prio_group, 8'h00};
         default: begin
            for (int f = 0; f < NUM_FLT; f++)
               if (addr == OFS_FLT0 + 12'(4 * f)) rd_word = flt_stat[f*32 +: 32];
         end
      endcase
   end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank #(
   parameter int NUM_EXT = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [11:0]          bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [3:0]           bus_be,
   input  logic                 bus_priv,
   output logic [31:0]          bus_rdata,
   output logic                 bus_rvalid,
   input  logic [NUM_EXT-1:0]   ena_stat,
   input  logic [NUM_EXT-1:0]   pend_stat,
   input  logic [NUM_EXT-1:0]   act_stat,
   input  logic [8*NUM_EXT-1:0] prio_stat,
   input  logic [95:0]          sys_prio_stat,
   input  logic [8:0]           cur_exc,
   input  logic [8:0]           pend_vec,
   input  logic                 ret_to_base,
   input  logic                 ext_pend,
   input  logic                 tick_pend,
   input  logic                 soft_pend,
   input  logic                 nmi_pend,
   input  logic                 usr_pend_en,
   input  logic [95:0]          flt_set,
   output logic [NUM_EXT-1:0]   ena_set,
   output logic [NUM_EXT-1:0]   ena_clr,
   output logic [NUM_EXT-1:0]   pend_set,
   output logic [NUM_EXT-1:0]   pend_clr,
   output logic [3:0]           prio_we,
   output logic [8:0]           prio_exc,
   output logic [31:0]          prio_wdata,
   output logic                 nmi_set,
   output logic                 soft_set,
   output logic                 soft_clr,
   output logic                 tick_set,
   output logic                 tick_clr,
   output logic                 sys_rst_req,
   output logic [2:0]           prio_group,
   output logic [31:0]          vtab_base,
   output logic [95:0]          flt_stat
);
   generate
      if (NUM_EXT % 32 != 0 || NUM_EXT < 32 || NUM_EXT > 480) begin : g_bad_cfg
         $error("irq_regbank: NUM_EXT must be a multiple of 32 in 32..480");
      end
   endgenerate

   logic               wr;
   logic [NUM_EXT-1:0] es_d, ec_d, ps_d, pc_d, dummy_s, dummy_c, trig_d;
   logic [31:0]        rd_en, rd_pd, rd_ac, rd_pr, rd_sc;
   logic [3:0]         pwe_d;
   logic [8:0]         pexc_d;
   logic               nmi_d, ss_d, sc_d, ts_d, tc_d, rr_d;

   assign wr = bus_sel && bus_wr;

   irq_rb_bitmap #(.NUM_EXT(NUM_EXT), .SET_OFS(12'h100), .CLR_OFS(12'h180), .WRITABLE(1'b1))
      u_ena (.wr(wr), .addr(bus_addr), .wdata(bus_wdata), .be(bus_be), .stat(ena_stat),
             .set_o(es_d), .clr_o(ec_d), .rd_word(rd_en));
   irq_rb_bitmap #(.NUM_EXT(NUM_EXT), .SET_OFS(12'h200), .CLR_OFS(12'h280), .WRITABLE(1'b1))
      u_pend (.wr(wr), .addr(bus_addr), .wdata(bus_wdata), .be(bus_be), .stat(pend_stat),
              .set_o(ps_d), .clr_o(pc_d), .rd_word(rd_pd));
   irq_rb_bitmap #(.NUM_EXT(NUM_EXT), .SET_OFS(12'h300), .CLR_OFS(12'h300), .WRITABLE(1'b0))
      u_act (.wr(wr), .addr(bus_addr), .wdata(bus_wdata), .be(bus_be), .stat(act_stat),
             .set_o(dummy_s), .clr_o(dummy_c), .rd_word(rd_ac));

   irq_rb_prio #(.NUM_EXT(NUM_EXT)) u_prio (
      .wr(wr), .addr(bus_addr), .be(bus_be), .prio_stat(prio_stat),
      .sys_prio_stat(sys_prio_stat), .we_o(pwe_d), .exc_o(pexc_d), .rd_word(rd_pr));

   irq_rb_sysctl #(.NUM_EXT(NUM_EXT)) u_sys (
      .clk(clk), .rst_n(rst_n), .wr(wr), .addr(bus_addr), .wdata(bus_wdata), .be(bus_be),
      .priv(bus_priv), .usr_pend_en(usr_pend_en), .cur_exc(cur_exc), .pend_vec(pend_vec),
      .ret_to_base(ret_to_base), .ext_pend(ext_pend), .tick_pend(tick_pend),
      .soft_pend(soft_pend), .nmi_pend(nmi_pend), .flt_set(flt_set),
      .nmi_set_d(nmi_d), .soft_set_d(ss_d), .soft_clr_d(sc_d), .tick_set_d(ts_d),
      .tick_clr_d(tc_d), .rst_req_d(rr_d), .trig_vec(trig_d), .prio_group(prio_group),
      .vtab_base(vtab_base), .flt_stat(flt_stat), .rd_word(rd_sc));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ena_set <= '0;  ena_clr <= '0;  pend_set <= '0;  pend_clr <= '0;
         prio_we <= '0;  prio_exc <= '0; prio_wdata <= '0;
         nmi_set <= 1'b0; soft_set <= 1'b0; soft_clr <= 1'b0;
         tick_set <= 1'b0; tick_clr <= 1'b0; sys_rst_req <= 1'b0;
         bus_rdata <= '0; bus_rvalid <= 1'b0;
      end else begin
         ena_set     <= es_d;
         ena_clr     <= ec_d;
         pend_set    <= ps_d | trig_d;
         pend_clr    <= pc_d;
         prio_we     <= pwe_d;
         prio_exc    <= pexc_d;
         prio_wdata  <= bus_wdata;
         nmi_set     <= nmi_d;
         soft_set    <= ss_d;
         soft_clr    <= sc_d;
         tick_set    <= ts_d;
         tick_clr    <= tc_d;
         sys_rst_req <= rr_d;
         bus_rvalid  <= bus_sel && !bus_wr;
         if (bus_sel && !bus_wr) bus_rdata <= rd_en | rd_pd | rd_ac | rd_pr | rd_sc;
      end
   end
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
   parameter int NUM_EXT = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [11:0]        bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [3:0]         bus_be,
   input logic               bus_rvalid,
   input logic [NUM_EXT-1:0] ena_set,
   input logic [NUM_EXT-1:0] ena_clr,
   input logic [NUM_EXT-1:0] pend_set,
   input logic [NUM_EXT-1:0] pend_clr,
   input logic               soft_set,
   input logic               soft_clr,
   input logic               tick_set,
   input logic               tick_clr,
   input logic               sys_rst_req,
   input logic [2:0]         prio_group,
   input logic [95:0]        flt_set,
   input logic [95:0]        flt_stat
);
   logic key_wr;
   assign key_wr = bus_sel && bus_wr && bus_addr == 12'hD0C && bus_be == 4'hF
                   && bus_wdata[31:16] == 16'h05FA;

   a_r1_ena_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_set != '0 || ena_clr != '0) |-> $past(bus_sel && bus_wr && bus_addr[11:8] == 4'h1));

   a_r2_pend_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_set != '0 || pend_clr != '0) |->
         $past(bus_sel && bus_wr && (bus_addr[11:8] == 4'h2 || bus_addr == 12'hF00)));

   a_r3_active_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_sel && bus_wr && bus_addr[11:8] == 4'h3) |->
         (ena_set == '0 && ena_clr == '0 && pend_set == '0 && pend_clr == '0));

   a_r8_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(soft_set && soft_clr) && !(tick_set && tick_clr));

   a_r9_group_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prio_group) |-> $past(key_wr));

   a_r9_reset_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> $past(key_wr && bus_wdata[2]));

   a_r11_fault_set_source: assert property (@(posedge clk) disable iff (!rst_n)
      ((flt_stat & ~$past(flt_stat)) & ~$past(flt_set)) == '0);

   a_r13_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid == $past(bus_sel && !bus_wr));
endmodule

bind irq_regbank irq_regbank_chk #(.NUM_EXT(NUM_EXT)) u_chk (.*);

// File: tb/irq_regbank_test.sv
`timescale 1ns/1ps
module irq_regbank_test;
   localparam int N = 64;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_sel = 0, bus_wr = 0, bus_priv = 0, usr_pend_en = 0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [N-1:0] ena_stat, pend_stat, act_stat;
   logic [8*N-1:0] prio_stat;
   logic [95:0] sys_prio_stat, flt_set = '0, flt_stat;
   logic [8:0]  cur_exc = 9'h013, pend_vec = 9'h025;
   logic ret_to_base = 1, ext_pend = 1, tick_pend = 1, soft_pend = 0, nmi_pend = 1;
   logic [N-1:0] ena_set, ena_clr, pend_set, pend_clr;
   logic [3:0]  prio_we;
   logic [8:0]  prio_exc;
   logic [31:0] prio_wdata, vtab_base;
   logic nmi_set, soft_set, soft_clr, tick_set, tick_clr, sys_rst_req;
   logic [2:0] prio_group;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   irq_regbank #(.NUM_EXT(N)) uut (.*);

   // {address, expected read data} walked with fixed status inputs
   localparam logic [43:0] RD_TBL [19] = '{
      {12'h004, 32'h0000_0001},   // R12 type word
      {12'h100, 32'h1234_5678},   // R1
      {12'h104, 32'hF0F0_0000},   // R1
      {12'h180, 32'h1234_5678},   // R1 alias
      {12'h184, 32'hF0F0_0000},   // R1 alias
      {12'h108, 32'h0000_0000},   // R1 past last line
      {12'h200, 32'h8000_0000},   // R2
      {12'h284, 32'h0000_0001},   // R2 alias
      {12'h300, 32'h0000_0003},   // R3
      {12'h304, 32'hA5A5_0000},   // R3
      {12'h400, 32'h0302_0100},   // R5
      {12'h43C, 32'h3F3E_3D3C},   // R5
      {12'h440, 32'h0000_0000},   // R5 past last line
      {12'hD18, 32'h8382_8180},   // R6
      {12'hD20, 32'h8B8A_8988},   // R6
      {12'hD04, 32'h8442_5813},   // R7
      {12'hD0C, 32'hFA05_0000},   // R9
      {12'h800, 32'h0000_0000},   // R13 unmapped
      {12'hD08, 32'h0000_0000}    // R12 reset value
   };

   function automatic string req_of(input logic [11:0] a);
      if (a == 12'h004 || a == 12'hD08) return "R12";
      if (a[11:8] == 4'h1) return "R1";
      if (a[11:8] == 4'h2) return "R2";
      if (a[11:8] == 4'h3) return "R3";
      if (a[11:8] == 4'h4) return "R5";
      if (a[11:4] == 8'hD1 || a[11:4] == 8'hD2) return "R6";
      if (a == 12'hD04) return "R7";
      if (a == 12'hD0C) return "R9";
      return "R13";
   endfunction

   task automatic chk(input string req, input logic [95:0] got, input logic [95:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr_bus(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd_bus(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = 4'hF;
      @(negedge clk);
      bus_sel = 0;
      d = bus_rdata;
      chk("R13 rvalid", {95'b0, bus_rvalid}, 96'd1);
   endtask

   task automatic strobes_zero(input string req);
      chk(req, {ena_set, ena_clr}, '0);
      chk(req, {pend_set, pend_clr}, '0);
      chk(req, {83'b0, prio_we, nmi_set, soft_set, soft_clr, tick_set, tick_clr, sys_rst_req}, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      ena_stat  = 64'hF0F0_0000_1234_5678;
      pend_stat = 64'h0000_0001_8000_0000;
      act_stat  = 64'hA5A5_0000_0000_0003;
      for (int k = 0; k < N; k++)  prio_stat[k*8 +: 8] = 8'(k);
      for (int k = 0; k < 12; k++) sys_prio_stat[k*8 +: 8] = 8'(8'h80 + k);

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state, R9 R11 R12 R13
      strobes_zero("R13 reset strobes");
      chk("R9 reset group", {93'b0, prio_group}, '0);
      chk("R12 reset vtab", {64'b0, vtab_base}, '0);
      chk("R11 reset fault", flt_stat, '0);

      for (int i = 0; i < 19; i++) begin
         rd_bus(RD_TBL[i][43:32], d);
         chk(req_of(RD_TBL[i][43:32]), {64'b0, d}, {64'b0, RD_TBL[i][31:0]});
      end

      // R1 set/clear strobes, one cycle after the write
      wr_bus(12'h100, 32'h0000_0005, 4'hF);
      chk("R1 ena_set", {32'b0, ena_set}, 96'h5);
      chk("R1 ena_clr idle", {32'b0, ena_clr}, '0);
      @(negedge clk);
      chk("R1 one-cycle strobe", {32'b0, ena_set}, '0);
      wr_bus(12'h184, 32'h8000_0000, 4'hF);
      chk("R1 ena_clr line 63", {32'b0, ena_clr}, {32'b0, 64'h8000_0000_0000_0000});
      wr_bus(12'h108, 32'hFFFF_FFFF, 4'hF);
      strobes_zero("R1 word past last line");

      // R2 and R4 byte lanes
      wr_bus(12'h200, 32'hFFFF_FFFF, 4'b0010);
      chk("R4 pend_set lane1", {32'b0, pend_set}, 96'hFF00);
      wr_bus(12'h284, 32'h0000_0101, 4'hF);
      chk("R2 pend_clr", {32'b0, pend_clr}, {32'b0, 64'h0000_0101_0000_0000});

      // R3 active is read-only
      wr_bus(12'h300, 32'hFFFF_FFFF, 4'hF);
      strobes_zero("R3 active write");

      // R5 priority writes
      wr_bus(12'h404, 32'hAABB_CCDD, 4'b1010);
      chk("R5 prio_we", {92'b0, prio_we}, 96'hA);
      chk("R5 prio_exc", {87'b0, prio_exc}, 96'd20);
      chk("R5 prio_wdata", {64'b0, prio_wdata}, 96'hAABB_CCDD);
      wr_bus(12'h43C, 32'h1111_1111, 4'hF);
      chk("R5 prio last word exc", {87'b0, prio_exc}, 96'd76);
      chk("R5 prio last word we", {92'b0, prio_we}, 96'hF);
      wr_bus(12'h440, 32'h1111_1111, 4'hF);
      chk("R5 prio past last line", {92'b0, prio_we}, '0);

      // R6 system priority
      wr_bus(12'hD1C, 32'h0000_0040, 4'b0001);
      chk("R6 sys prio exc", {87'b0, prio_exc}, 96'd8);
      chk("R6 sys prio we", {92'b0, prio_we}, 96'h1);

      // R8 control/state writes
      wr_bus(12'hD04, 32'h9800_0000, 4'hF);
      chk("R8 nmi/soft set wins", {91'b0, nmi_set, soft_set, soft_clr, tick_set, tick_clr}, 96'b11000);
      wr_bus(12'hD04, 32'h0A00_0000, 4'hF);
      chk("R8 clears", {91'b0, nmi_set, soft_set, soft_clr, tick_set, tick_clr}, 96'b00101);
      wr_bus(12'hD04, 32'h0600_0000, 4'hF);
      chk("R8 tick set wins", {91'b0, nmi_set, soft_set, soft_clr, tick_set, tick_clr}, 96'b00010);
      wr_bus(12'hD04, 32'h8000_0000, 4'b0111);
      chk("R13 partial ctrl write", {95'b0, nmi_set}, '0);

      // R9 key
      wr_bus(12'hD0C, 32'h1234_0504, 4'hF);
      chk("R9 bad key rst", {95'b0, sys_rst_req}, '0);
      chk("R9 bad key group", {93'b0, prio_group}, '0);
      wr_bus(12'hD0C, 32'h05FA_0504, 4'hF);
      chk("R9 rst pulse", {95'b0, sys_rst_req}, 96'd1);
      chk("R9 group", {93'b0, prio_group}, 96'd5);
      @(negedge clk);
      chk("R9 rst one cycle", {95'b0, sys_rst_req}, '0);
      rd_bus(12'hD0C, d);
      chk("R9 readback", {64'b0, d}, 96'hFA05_0500);

      // R10 software trigger
      bus_priv = 0; usr_pend_en = 0;
      wr_bus(12'hF00, 32'd3, 4'hF);
      chk("R10 user blocked", {32'b0, pend_set}, '0);
      bus_priv = 1;
      wr_bus(12'hF00, 32'd3, 4'hF);
      chk("R10 privileged", {32'b0, pend_set}, 96'h8);
      wr_bus(12'hF00, 32'd64, 4'hF);
      chk("R10 out of range", {32'b0, pend_set}, '0);
      bus_priv = 0; usr_pend_en = 1;
      wr_bus(12'hF00, 32'd63, 4'hF);
      chk("R10 user allowed", {32'b0, pend_set}, {32'b0, 64'h8000_0000_0000_0000});
      usr_pend_en = 0;

      // R11 fault words
      @(negedge clk);
      flt_set = 96'h20;
      @(negedge clk);
      flt_set = '0;
      chk("R11 set", flt_stat, 96'h20);
      rd_bus(12'hD28, d);
      chk("R11 read", {64'b0, d}, 96'h20);
      wr_bus(12'hD28, 32'h20, 4'hF);
      chk("R11 clear", flt_stat, '0);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = 12'hD2C; bus_wdata = 32'h1; bus_be = 4'hF;
      flt_set = {32'h0, 32'h1, 32'h0};
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; flt_set = '0;
      chk("R11 set beats clear", flt_stat, {32'h0, 32'h1, 32'h0});

      // R12 vector base
      wr_bus(12'hD08, 32'h1234_567F, 4'hF);
      chk("R12 vtab mask", {64'b0, vtab_base}, 96'h1234_5600);
      wr_bus(12'hD08, 32'hFFFF_FFFF, 4'b0011);
      chk("R13 partial vtab write", {64'b0, vtab_base}, 96'h1234_5600);
      rd_bus(12'hD08, d);
      chk("R12 vtab read", {64'b0, d}, 96'h1234_5600);

      // R13 unmapped write then read
      wr_bus(12'h800, 32'hFFFF_FFFF, 4'hF);
      strobes_zero("R13 unmapped write");
      rd_bus(12'h800, d);
      chk("R13 unmapped read", {64'b0, d}, '0);
      @(negedge clk);
      chk("R13 rvalid drops", {95'b0, bus_rvalid}, '0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule